// File: doc/BRIEF.md
# Timer Channel Clock Gating Controller

This block decides whether one timer/counter channel counts. Its state is held in two layers. The outer layer is an enable latch. Explicit enable and disable strobes set and clear it, and a mode-dependent hardware event can also clear it. The inner layer is a run latch. It only has meaning while the enable latch is set: a trigger sets it, and a mode-dependent hardware event can clear it. The channel counts on a selected-clock tick only when both latches are set. A small counter is included so that the gating can be seen at the ports.

The channel works in one of two modes, capture or waveform, chosen by a single mode bit. In capture mode the automatic events come from loads of capture register B. In waveform mode they come from register C compare matches. Four option bits choose whether each kind of event disables the clock or only stops it. A disable also clears the run latch, so after a re-enable the channel waits for a fresh trigger. A trigger arms a counter clear, and the clear takes effect on the next counted tick.

Top module: `tcg_top`

## Requirements
- R1: After reset, `clk_en_sta`, `cnt_gate` and `count` are all zero.
- R2: An `en_cmd` strobe sets `clk_en_sta` at the next edge and a `dis_cmd` strobe clears it. When both strobes arrive in one cycle, `dis_cmd` wins.
- R3: When `wave_mode`=0 (capture) and `opt_dis_bload`=1, a `bload_ev` pulse clears `clk_en_sta`. The pulse has no effect on `clk_en_sta` if the option is 0 or if `wave_mode`=1.
- R4: When `wave_mode`=1 (waveform) and `opt_dis_ccmp`=1, a `ccmp_ev` pulse clears `clk_en_sta`. The pulse has no effect on `clk_en_sta` if the option is 0 or if `wave_mode`=0.
- R5: While the channel is disabled, triggers are ignored and `cnt_gate` stays 0. A disable clears the run latch, so after a later `en_cmd` the gate stays 0 until a trigger arrives.
- R6: A pulse on any bit of `trig` sets `cnt_gate` at the next edge if the enable latch is set after that edge. This includes a trigger that arrives in the same cycle as `en_cmd`.
- R7: A stop event clears `cnt_gate` but leaves `clk_en_sta` set. The stop event is `bload_ev` with `opt_stop_bload`=1 in capture mode, or `ccmp_ev` with `opt_stop_ccmp`=1 in waveform mode. The event belonging to the other mode does not stop the channel.
- R8: When a trigger and a stop event arrive in the same cycle, the trigger wins and `cnt_gate` is 1 after the edge.
- R9: `count` changes only at an edge where `tick`=1 and `cnt_gate`=1. Otherwise it holds its value.
- R10: The first counted tick after an accepted trigger loads `count` with 0. Each later counted tick adds 1, and the count wraps from 2^COUNT_W-1 to 0.
- R11: `io_inputs` is 1 in capture mode (`wave_mode`=0) and 0 in waveform mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Selected counting clock tick |
| en_cmd | input | 1 | Enable command strobe |
| dis_cmd | input | 1 | Disable command strobe |
| trig | input | TRIG_W | Trigger strobes (software, sync, external, compare) |
| wave_mode | input | 1 | 0 = capture, 1 = waveform |
| opt_dis_bload | input | 1 | Disable on B load (capture) |
| opt_stop_bload | input | 1 | Stop on B load (capture) |
| opt_dis_ccmp | input | 1 | Disable on C compare (waveform) |
| opt_stop_ccmp | input | 1 | Stop on C compare (waveform) |
| bload_ev | input | 1 | Capture register B load event |
| ccmp_ev | input | 1 | Register C compare match event |
| cnt_gate | output | 1 | Counter clock gate (enabled and started) |
| clk_en_sta | output | 1 | Enable latch status |
| io_inputs | output | 1 | Timer I/O pins act as inputs |
| count | output | COUNT_W | Counter value |

## Verification
A wrong enable latch shows on `clk_en_sta` one edge after the strobe or event that caused it. A wrong run latch shows on `cnt_gate` one edge after the trigger or stop. The mode checks pair each event with each option in both modes, so a decode that uses the wrong mode appears as a status or gate bit that changes when it should hold. A clear that is lost, or one that comes early, shows on `count` at the first counted tick after the trigger. The wrap is checked at the full counter width.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
   typedef enum logic {
      TCG_CAPTURE  = 1'b0,
      TCG_WAVEFORM = 1'b1
   } tcg_mode_e;

   typedef struct packed {
      logic dis_bload;
      logic stop_bload;
      logic dis_ccmp;
      logic stop_ccmp;
   } tcg_opts_t;
endpackage

// File: rtl/tcg_event_decode.sv
module tcg_event_decode
   import tcg_pkg::*;
(
   input  tcg_mode_e mode,
   input  tcg_opts_t opts,
   input  logic      bload_ev,
   input  logic      ccmp_ev,
   output logic      auto_dis,
   output logic      auto_stop
);
   logic cap_mode;
   logic wav_mode;

   assign cap_mode = (mode == TCG_CAPTURE);
   assign wav_mode = (mode == TCG_WAVEFORM);

   always_comb begin
      auto_dis  = (cap_mode & opts.dis_bload  & bload_ev) |
                  (wav_mode & opts.dis_ccmp   & ccmp_ev);
      auto_stop = (cap_mode & opts.stop_bload & bload_ev) |
                  (wav_mode & opts.stop_ccmp  & ccmp_ev);
   end
endmodule

// File: rtl/tcg_enable_latch.sv
module tcg_enable_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic en_cmd,
   input  logic dis_cmd,
   input  logic auto_dis,
   output logic en_next,
   output logic en_q
);
   logic clr_any;

   assign clr_any = dis_cmd | auto_dis;

   always_comb begin
      if (clr_any)      en_next = 1'b0;
      else if (en_cmd)  en_next = 1'b1;
      else              en_next = en_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_next;
   end

   // R2
   dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_cmd |=> !en_q);

   // R2
   en_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> $past(en_cmd));
endmodule

// File: rtl/tcg_run_latch.sv
module tcg_run_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic en_next,
   input  logic trig_any,
   input  logic stop_ev,
   output logic trig_acc,
   output logic run_q
);
   logic run_next;

   assign trig_acc = trig_any & en_next;

   always_comb begin
      if (!en_next)      run_next = 1'b0;
      else if (trig_any) run_next = 1'b1;
      else if (stop_ev)  run_next = 1'b0;
      else               run_next = run_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= run_next;
   end

   // R8
   trig_beats_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_any && en_next) |=> run_q);
endmodule

// File: rtl/tcg_counter.sv
module tcg_counter #(
   parameter int COUNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               gate,
   input  logic               trig_acc,
   output logic [COUNT_W-1:0] count
);
   logic clr_pend;
   logic step;

   assign step = tick & gate;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         clr_pend <= 1'b0;
      end else begin
         if (step) begin
            if (clr_pend || trig_acc) count <= '0;
            else                      count <= count + 1'b1;
         end
         if (step)          clr_pend <= 1'b0;
         else if (trig_acc) clr_pend <= 1'b1;
      end
   end

   // R9
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && gate) |=> $stable(count));

   // R10
   clear_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && gate && clr_pend) |=> (count == '0));
endmodule

// File: rtl/tcg_top.sv
module tcg_top
   import tcg_pkg::*;
#(
   parameter int COUNT_W = 16,
   parameter int TRIG_W  = 4,
   parameter logic [TRIG_W-1:0] TRIG_MASK = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               en_cmd,
   input  logic               dis_cmd,
   input  logic [TRIG_W-1:0]  trig,
   input  logic               wave_mode,
   input  logic               opt_dis_bload,
   input  logic               opt_stop_bload,
   input  logic               opt_dis_ccmp,
   input  logic               opt_stop_ccmp,
   input  logic               bload_ev,
   input  logic               ccmp_ev,
   output logic               cnt_gate,
   output logic               clk_en_sta,
   output logic               io_inputs,
   output logic [COUNT_W-1:0] count
);
   if (COUNT_W < 2) begin : g_bad_width
      $error("tcg_top: COUNT_W must be at least 2");
   end
   if (TRIG_W < 1) begin : g_bad_trig
      $error("tcg_top: TRIG_W must be at least 1");
   end

   tcg_mode_e         mode;
   tcg_opts_t         opts;
   logic [TRIG_W-1:0] trig_used;
   logic              trig_any;
   logic              auto_dis;
   logic              auto_stop;
   logic              en_next;
   logic              en_q;
   logic              run_q;
   logic              trig_acc;

   assign mode = wave_mode ? TCG_WAVEFORM : TCG_CAPTURE;
   assign opts = '{dis_bload: opt_dis_bload, stop_bload: opt_stop_bload,
                   dis_ccmp: opt_dis_ccmp, stop_ccmp: opt_stop_ccmp};

   for (genvar gi = 0; gi < TRIG_W; gi++) begin : g_trig
      if (TRIG_MASK[gi]) begin : g_on
         assign trig_used[gi] = trig[gi];
      end else begin : g_off
         assign trig_used[gi] = 1'b0;
      end
   end
   assign trig_any = |trig_used;

   tcg_event_decode u_dec (
      .mode      (mode),
      .opts      (opts),
      .bload_ev  (bload_ev),
      .ccmp_ev   (ccmp_ev),
      .auto_dis  (auto_dis),
      .auto_stop (auto_stop)
   );

   tcg_enable_latch u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_cmd   (en_cmd),
      .dis_cmd  (dis_cmd),
      .auto_dis (auto_dis),
      .en_next  (en_next),
      .en_q     (en_q)
   );

   tcg_run_latch u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_next  (en_next),
      .trig_any (trig_any),
      .stop_ev  (auto_stop),
      .trig_acc (trig_acc),
      .run_q    (run_q)
   );

   assign cnt_gate   = en_q & run_q;
   assign clk_en_sta = en_q;
   assign io_inputs  = (mode == TCG_CAPTURE);

   tcg_counter #(.COUNT_W(COUNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .gate     (cnt_gate),
      .trig_acc (trig_acc),
      .count    (count)
   );

   // R5
   run_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> en_q);

   // R7
   stop_clears_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_stop && !trig_any) |=> !cnt_gate);

   // R3
   cap_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wave_mode && opt_dis_bload && bload_ev) |=> !clk_en_sta);

   // R4
   wav_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_mode && opt_dis_ccmp && ccmp_ev) |=> !clk_en_sta);
endmodule

// File: tb/tcg_top_test.sv
module tcg_top_test;
   localparam int W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, en_cmd = 1'b0, dis_cmd = 1'b0;
   logic [3:0] trig = '0;
   logic wave_mode = 1'b0;
   logic opt_dis_bload = 1'b0, opt_stop_bload = 1'b0;
   logic opt_dis_ccmp = 1'b0, opt_stop_ccmp = 1'b0;
   logic bload_ev = 1'b0, ccmp_ev = 1'b0;
   logic cnt_gate, clk_en_sta, io_inputs;
   logic [W-1:0] count;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tcg_top #(.COUNT_W(W), .TRIG_W(4)) uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
      .trig(trig), .wave_mode(wave_mode), .opt_dis_bload(opt_dis_bload),
      .opt_stop_bload(opt_stop_bload), .opt_dis_ccmp(opt_dis_ccmp),
      .opt_stop_ccmp(opt_stop_ccmp), .bload_ev(bload_ev), .ccmp_ev(ccmp_ev),
      .cnt_gate(cnt_gate), .clk_en_sta(clk_en_sta), .io_inputs(io_inputs),
      .count(count)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      en_cmd = 0; dis_cmd = 0; trig = '0; bload_ev = 0; ccmp_ev = 0;
   endtask

   task automatic clear_opts();
      opt_dis_bload = 0; opt_stop_bload = 0; opt_dis_ccmp = 0; opt_stop_ccmp = 0;
      tick = 0;
   endtask

   task automatic t_reset();
      chk("R1 sta", clk_en_sta, 0);
      chk("R1 gate", cnt_gate, 0);
      chk("R1 count", count, 0);
      chk("R11 capture io", io_inputs, 1);
   endtask

   task automatic t_enable();
      en_cmd = 1; step();
      chk("R2 enable", clk_en_sta, 1);
      chk("R5 no start on enable", cnt_gate, 0);
      dis_cmd = 1; step();
      chk("R2 disable", clk_en_sta, 0);
      en_cmd = 1; dis_cmd = 1; step();
      chk("R2 disable wins", clk_en_sta, 0);
   endtask

   task automatic t_disabled();
      trig = 4'b0010; step();
      chk("R5 trig ignored", cnt_gate, 0);
      en_cmd = 1; trig = 4'b0001; step();
      chk("R6 trig with enable", cnt_gate, 1);
      dis_cmd = 1; step();
      chk("R5 disable stops", cnt_gate, 0);
      en_cmd = 1; step();
      chk("R5 reenable stopped", cnt_gate, 0);
      chk("R5 reenable sta", clk_en_sta, 1);
      trig = 4'b0100; step();
      chk("R6 trig bit2", cnt_gate, 1);
      trig = 4'b1000; step();
      chk("R6 trig bit3", cnt_gate, 1);
   endtask

   task automatic t_count();
      clear_opts();
      dis_cmd = 1; step();
      en_cmd = 1; trig = 4'b0001; step();
      repeat (3) step();
      tick = 1; step();
      chk("R10 clear on first tick", count, 0);
      repeat (3) step();
      chk("R9 counts ticks", count, 3);
      tick = 0; step(); step();
      chk("R9 holds without tick", count, 3);
      wave_mode = 0; opt_stop_bload = 1; tick = 1; bload_ev = 1; step();
      chk("R9 tick at stop edge", count, 4);
      chk("R7 stopped", cnt_gate, 0);
      step(); step();
      chk("R9 holds while stopped", count, 4);
      chk("R7 still enabled", clk_en_sta, 1);
      tick = 0; trig = 4'b0010; step();
      chk("R6 restart", cnt_gate, 1);
      chk("R10 no clear before tick", count, 4);
      tick = 1; step();
      chk("R10 clear after restart", count, 0);
      tick = 0;
      clear_opts();
   endtask

   task automatic t_wave_stop();
      clear_opts();
      wave_mode = 1;
      step();
      chk("R11 waveform io", io_inputs, 0);
      opt_stop_bload = 1; bload_ev = 1; step();
      chk("R7 B load no stop in waveform", cnt_gate, 1);
      opt_stop_ccmp = 1; ccmp_ev = 1; step();
      chk("R7 compare stop", cnt_gate, 0);
      chk("R7 compare stop keeps enable", clk_en_sta, 1);
      trig = 4'b0001; ccmp_ev = 1; step();
      chk("R8 trigger beats stop", cnt_gate, 1);
      wave_mode = 0; opt_stop_bload = 0; ccmp_ev = 1; step();
      chk("R7 compare no stop in capture", cnt_gate, 1);
      clear_opts();
   endtask

   task automatic t_dis_events();
      clear_opts();
      wave_mode = 0; opt_dis_bload = 1; bload_ev = 1; step();
      chk("R3 B load disables", clk_en_sta, 0);
      chk("R3 gate off", cnt_gate, 0);
      en_cmd = 1; opt_dis_bload = 0; step();
      bload_ev = 1; step();
      chk("R3 option off", clk_en_sta, 1);
      wave_mode = 1; opt_dis_bload = 1; bload_ev = 1; step();
      chk("R3 no disable in waveform", clk_en_sta, 1);
      opt_dis_ccmp = 1; ccmp_ev = 1; step();
      chk("R4 compare disables", clk_en_sta, 0);
      en_cmd = 1; opt_dis_ccmp = 0; step();
      ccmp_ev = 1; step();
      chk("R4 option off", clk_en_sta, 1);
      wave_mode = 0; opt_dis_bload = 0; opt_dis_ccmp = 1; ccmp_ev = 1; step();
      chk("R4 no disable in capture", clk_en_sta, 1);
      clear_opts();
   endtask

   task automatic t_wrap();
      clear_opts();
      wave_mode = 0;
      dis_cmd = 1; step();
      en_cmd = 1; trig = 4'b0001; step();
      tick = 1;
      repeat (1 << W) step();
      chk("R10 top value", count, (1 << W) - 1);
      step();
      chk("R10 wrap to zero", count, 0);
      tick = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_disabled();
      t_count();
      t_wave_stop();
      t_dis_events();
      t_wrap();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule